// File: doc/BRIEF.md
# DFA Parallel Prefix Recognizer

This block decides whether a fixed-length word of symbols belongs to a regular language. The automaton is fixed at elaboration time: alphabet size, number of states, transition table, start state and accepting set are all parameters. The whole word arrives at once as a packed vector. The block does not step the automaton one symbol at a time. Instead, each symbol becomes a state-to-state map. Neighbouring maps are composed pairwise in a balanced binary tree, so the logic depth grows with the logarithm of the word length and not with the length itself.

The root of the tree holds the map for the full word. Applying that map to the start state gives the end state, which is brought out directly. The accept bit looks the end state up in the accepting mask. It can leave the block combinationally, or through one register, which is the default.

Top module: `dfa_tree_recognizer`

## Requirements
- R1: Symbol j of the word sits at bits [j*SYW +: SYW] of `word_i`. Symbol 0 is consumed first and symbol N-1 last. For a language that is not commutative, the order changes the result.
- R2: `end_state_o` equals the state reached by starting at START and stepping through all N symbols. The next state from state q on symbol s is the QW-bit field at bits [(q*NA+s)*QW +: QW] of TRANS.
- R3: The accept result is bit e of the ACCEPT mask, where e is the end state of R2.
- R4: With REG_OUT=1, `accept_o` shows the result for the word present at the previous rising clock edge. A change of the word between edges does not reach `accept_o` before the next edge. With REG_OUT=0, `accept_o` follows the word combinationally.
- R5: With REG_OUT=1, a rising edge with `rst_n` low clears `accept_o` to 0, whatever the word. `end_state_o` is not affected by reset.
- R6: For every word made of symbols below NA, `end_state_o` is below NQ.
- R7: When N is not a power of two, the unused leaves of the tree act as the identity map. The result depends only on the N real symbols, exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional accept register |
| rst_n | input | 1 | Synchronous active-low reset of the accept register |
| word_i | input | N*SYW | Packed input word, symbol 0 in the lowest bits |
| accept_o | output | 1 | 1 when the word is in the language |
| end_state_o | output | QW | State reached after the whole word (combinational) |

## Verification
The assertions take for granted that every symbol in `word_i` is below NA. Out-of-range codes would index past the transition table. With the default two-symbol alphabet every bit pattern is legal, so the stimulus cannot leave that set. The second instance also uses a two-symbol alphabet, which keeps it inside the assumption as well. The checker compares each result against its own serial walk of the automaton. The bench covers the counting language exhaustively and uses an order-sensitive language on a five-symbol word, so that symbol order and the padded leaves both show up at the ports.

// File: rtl/dfa_tree_recognizer.sv
module dfa_tree_recognizer #(
  parameter int N  = 8,
  parameter int NA = 2,
  parameter int NQ = 3,
  localparam int SYW = (NA > 1) ? $clog2(NA) : 1,
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1,
  parameter logic [NQ*NA*QW-1:0] TRANS = 12'h294,
  parameter int START = 0,
  parameter logic [NQ-1:0] ACCEPT = 3'b001,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N*SYW-1:0]  word_i,
  output logic              accept_o,
  output logic [QW-1:0]     end_state_o
);

  localparam int DEPTH  = (N > 1) ? $clog2(N) : 1;
  localparam int LEAVES = 1 << DEPTH;
  localparam int MW     = NQ * QW;

  function automatic logic [MW-1:0] leaf_map(input logic [SYW-1:0] s);
    logic [MW-1:0] m;
    for (int q = 0; q < NQ; q++)
      m[q*QW +: QW] = TRANS[(q*NA + int'(s))*QW +: QW];
    return m;
  endfunction

  function automatic logic [MW-1:0] ident_map();
    logic [MW-1:0] m;
    for (int q = 0; q < NQ; q++)
      m[q*QW +: QW] = QW'(q);
    return m;
  endfunction

  // left range first, then right range
  function automatic logic [MW-1:0] compose(input logic [MW-1:0] lm, input logic [MW-1:0] rm);
    logic [MW-1:0] m;
    logic [QW-1:0] mid;
    for (int q = 0; q < NQ; q++) begin
      mid = lm[q*QW +: QW];
      m[q*QW +: QW] = rm[int'(mid)*QW +: QW];
    end
    return m;
  endfunction

  logic [2*LEAVES-1:1][MW-1:0] node;

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N) begin : g_sym
      assign node[LEAVES+i] = leaf_map(word_i[i*SYW +: SYW]);
    end else begin : g_pad
      assign node[LEAVES+i] = ident_map();
    end
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    assign node[k] = compose(node[2*k], node[2*k+1]);
  end

  logic acc_c;
  assign end_state_o = node[1][START*QW +: QW];
  assign acc_c       = ACCEPT[end_state_o];

  if (REG_OUT) begin : g_reg
    logic acc_q;
    always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= 1'b0;
      else        acc_q <= acc_c;
    end
    assign accept_o = acc_q;
  end else begin : g_comb
    assign accept_o = acc_c;
  end

endmodule

// File: rtl/dfa_tree_recognizer_chk.sv
module dfa_tree_recognizer_chk #(
  parameter int N  = 8,
  parameter int NA = 2,
  parameter int NQ = 3,
  localparam int SYW = (NA > 1) ? $clog2(NA) : 1,
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1,
  parameter logic [NQ*NA*QW-1:0] TRANS = 12'h294,
  parameter int START = 0,
  parameter logic [NQ-1:0] ACCEPT = 3'b001,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N*SYW-1:0] word_i,
  input logic             accept_o,
  input logic [QW-1:0]    end_state_o
);

  function automatic logic [QW-1:0] walk(input logic [N*SYW-1:0] w);
    logic [QW-1:0] st;
    st = QW'(START);
    for (int j = 0; j < N; j++)
      st = TRANS[(int'(st)*NA + int'(w[j*SYW +: SYW]))*QW +: QW];
    return st;
  endfunction

  logic [QW-1:0] ref_st;
  assign ref_st = walk(word_i);

  // R2
  end_state_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_state_o == ref_st);

  // R6
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(end_state_o) < NQ);

  if (REG_OUT) begin : g_reg_chk
    logic seen, prev_acc, in_rst;
    always_ff @(posedge clk) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
      prev_acc <= ACCEPT[ref_st];
      in_rst   <= !rst_n;
    end

    // R4
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> accept_o == prev_acc);

    // R4
    accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $stable(word_i) |=> $stable(accept_o));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
      in_rst |-> !accept_o);
  end else begin : g_comb_chk
    // R3
    accept_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o == ACCEPT[ref_st]);
  end

endmodule

bind dfa_tree_recognizer dfa_tree_recognizer_chk #(
  .N(N), .NA(NA), .NQ(NQ), .TRANS(TRANS), .START(START),
  .ACCEPT(ACCEPT), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word_i(word_i),
  .accept_o(accept_o), .end_state_o(end_state_o)
);

// File: tb/dfa_tree_recognizer_bench.sv
module dfa_tree_recognizer_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] word = '0;
  logic [4:0] word2 = '0;
  logic acc, acc2;
  logic [1:0] st, st2;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // count of 1s divisible by 3, registered output
  dfa_tree_recognizer u_dfa_tree_recognizer (
    .clk(clk), .rst_n(rst_n), .word_i(word), .accept_o(acc), .end_state_o(st));

  // "a 1 followed later by a 0", 5 symbols, combinational output
  dfa_tree_recognizer #(.N(5), .TRANS(12'hA64), .ACCEPT(3'b100), .REG_OUT(1'b0)) u_pair (
    .clk(clk), .rst_n(rst_n), .word_i(word2), .accept_o(acc2), .end_state_o(st2));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mod3_state(input logic [7:0] w);
    return $countones(w) % 3;
  endfunction

  function automatic int pair_state(input logic [4:0] w);
    int s = 0;
    for (int j = 0; j < 5; j++) begin
      if (s == 0 && w[j]) s = 1;
      else if (s == 1 && !w[j]) s = 2;
    end
    return s;
  endfunction

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0; word = 8'h00;
    @(posedge clk); @(posedge clk); #1;
    check("R5 accept cleared in reset", int'(acc), 0);
    check("R5 end state live in reset", int'(st), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_mod3_all();
    for (int w = 0; w < 256; w++) begin
      @(negedge clk); word = 8'(w); #1;
      check("R2 end state", int'(st), mod3_state(8'(w)));
      check("R6 state range", int'(st < 2'd3), 1);
      @(posedge clk); #1;
      check("R3 accept", int'(acc), int'(mod3_state(8'(w)) == 0));
    end
  endtask

  task automatic t_latency();
    @(negedge clk); word = 8'h00;
    @(posedge clk); #1;
    check("R4 accept after edge", int'(acc), 1);
    @(negedge clk); word = 8'h01; #1;
    check("R4 accept held before edge", int'(acc), 1);
    check("R4 end state immediate", int'(st), 1);
    @(posedge clk); #1;
    check("R4 accept updates at edge", int'(acc), 0);
  endtask

  task automatic t_order();
    @(negedge clk); word2 = 5'b00001; #1;
    check("R1 first symbol 1 then 0s", int'(acc2), 1);
    word2 = 5'b10000; #1;
    check("R1 last symbol 1 only", int'(acc2), 0);
    for (int w = 0; w < 32; w++) begin
      word2 = 5'(w); #1;
      check("R2 pair end state", int'(st2), pair_state(5'(w)));
      check("R3 pair accept comb", int'(acc2), int'(pair_state(5'(w)) == 2));
    end
  endtask

  task automatic t_padding();
    @(negedge clk); word2 = 5'b10000; #1;
    check("R7 padding is identity", int'(st2), 1);
    word2 = 5'b00000; #1;
    check("R7 all zero stays at start", int'(st2), 0);
  endtask

  initial begin
    t_reset();
    t_mod3_all();
    t_latency();
    t_order();
    t_padding();
    t_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule